// File: doc/BRIEF.md
# Power Switch Wake and Status Latch

This block watches an active-low power-switch input that idles high because of a pull-up. The raw pin is synchronised and debounced, and the block then decides what a low means. While the device sleeps, an accepted low wakes it: the block moves to active mode and asserts the discharge-enable output. While the device is active, a low does nothing to the mode or to discharge. It only clears a sticky status flag.

The status flag is one bit of a feature register. It reads 1 when idle and 0 once a low has been seen. Software rearms it by writing a 1. The host enters sleep with a one-cycle request. The conditions that decide when to sleep are outside this block.

Top module: `pwrsw_wake`

## Requirements
- R1: After reset the block is in sleep (`is_active`=0), `dis_en`=0 and `flag_rdata`=1.
- R2: A low on `sw_n` is accepted only after it is seen on 3 consecutive synchronised samples. A shorter low pulse changes no output.
- R3: In sleep, an accepted low makes `is_active`=1 and `dis_en`=1. Both outputs change on the 7th rising edge after the pin falls.
- R4: In active mode, an accepted low leaves `is_active` and `dis_en` unchanged.
- R5: An accepted low, in either mode, makes `flag_rdata` read 0 from the cycle after acceptance.
- R6: A write (`flag_wr`=1) with `flag_wdata`=1 while the switch is high sets `flag_rdata` back to 1 on the next cycle. A later low then clears it again.
- R7: A write with `flag_wdata`=0 leaves `flag_rdata` unchanged.
- R8: `sleep_req`=1 in active mode gives `is_active`=0 and `dis_en`=0 after the next edge.
- R9: If the switch is still held low when a sleep request is taken, the block stays in sleep for exactly one cycle and is then active again.
- R10: A write of 1 made while a low is still accepted leaves `flag_rdata` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_n | input | 1 | Raw active-low switch pin, asynchronous |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| flag_wr | input | 1 | Write strobe for the status flag |
| flag_wdata | input | 1 | Write data for the flag; 1 rearms it, 0 is ignored |
| flag_rdata | output | 1 | Status flag; 0 means a low was latched |
| is_active | output | 1 | 1 in active mode, 0 in sleep |
| dis_en | output | 1 | Discharge enable |

## Verification
Low pulses 1 to 6 cycles wide are applied from sleep. Pulses of 1 and 2 cycles must leave every output untouched, and pulses of 3 cycles or more must wake the block, which pins down the debounce length. A single step of the pin is timed edge by edge to confirm the 7-edge latency. The same low is then applied in active mode, where only the flag may move. Flag writes of 0 and 1 are tried with the switch high and with it held low, which separates rearming from the rule that a new event wins. A sleep request is made both with the switch released and with it held, which tells a plain sleep from the one-cycle re-wake.

// File: rtl/pwrsw_pkg.sv
package pwrsw_pkg;
  typedef enum logic {
    MODE_SLEEP  = 1'b0,
    MODE_ACTIVE = 1'b1
  } pw_mode_t;
endpackage

// File: rtl/pwrsw_sync.sv
module pwrsw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwrsw_debounce.sv
module pwrsw_debounce #(
  parameter int SAMPLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_n,
  output logic low_seen
);
  logic [SAMPLES-1:0] hist;
  logic all_lo, all_hi;

  assign all_lo = (hist == '0);
  assign all_hi = &hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '1;
      low_seen <= 1'b0;
    end else begin
      hist <= {hist[SAMPLES-2:0], lvl_n};
      if (all_lo)      low_seen <= 1'b1;
      else if (all_hi) low_seen <= 1'b0;
    end
  end

  // A mixed history means a pulse too short to count, so the filtered level must hold.
  assert_glitch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!all_lo && !all_hi) |=> $stable(low_seen));
endmodule

// File: rtl/pwrsw_ctrl.sv
module pwrsw_ctrl
  import pwrsw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic low_seen,
  input  logic sleep_req,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic flag_q,
  output logic active_q,
  output logic dis_en_q
);
  pw_mode_t mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_SLEEP;
      dis_en_q <= 1'b0;
      flag_q   <= 1'b1;
    end else begin
      case (mode)
        MODE_SLEEP: begin
          if (low_seen) begin
            mode     <= MODE_ACTIVE;
            dis_en_q <= 1'b1;
          end
        end
        default: begin
          if (sleep_req) begin
            mode     <= MODE_SLEEP;
            dis_en_q <= 1'b0;
          end
        end
      endcase
      if (low_seen)                  flag_q <= 1'b0;
      else if (flag_wr && flag_wdata) flag_q <= 1'b1;
    end
  end

  assign active_q = (mode == MODE_ACTIVE);

  assert_wake_R3: assert property (@(posedge clk) disable iff (rst)
    (!active_q && low_seen) |=> (active_q && dis_en_q));
  assert_active_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (active_q && !sleep_req) |=> (active_q && dis_en_q));
  assert_flag_latch_R5: assert property (@(posedge clk) disable iff (rst)
    low_seen |=> !flag_q);
  assert_wr0_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!low_seen && !(flag_wr && flag_wdata)) |=> $stable(flag_q));
  assert_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    (active_q && sleep_req) |=> (!active_q && !dis_en_q));
endmodule

// File: rtl/pwrsw_wake.sv
module pwrsw_wake #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_SAMPLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_n,
  input  logic sleep_req,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic flag_rdata,
  output logic is_active,
  output logic dis_en
);
  logic sw_sync_n;
  logic low_seen;

  pwrsw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(sw_n), .q_sync(sw_sync_n)
  );

  pwrsw_debounce #(.SAMPLES(DEB_SAMPLES)) u_deb (
    .clk(clk), .rst(rst), .lvl_n(sw_sync_n), .low_seen(low_seen)
  );

  pwrsw_ctrl u_ctrl (
    .clk(clk), .rst(rst), .low_seen(low_seen), .sleep_req(sleep_req),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flag_q(flag_rdata),
    .active_q(is_active), .dis_en_q(dis_en)
  );

  // Discharge is never enabled while asleep.
  assert_dis_implies_active_R3: assert property (@(posedge clk) disable iff (rst)
    dis_en |-> is_active);
endmodule

// File: tb/test_pwrsw_wake.sv
module test_pwrsw_wake;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_n = 1'b1;
  logic sleep_req = 1'b0;
  logic flag_wr = 1'b0;
  logic flag_wdata = 1'b0;
  logic flag_rdata, is_active, dis_en;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwrsw_wake i_pwrsw_wake (
    .clk(clk), .rst(rst), .sw_n(sw_n), .sleep_req(sleep_req),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flag_rdata(flag_rdata),
    .is_active(is_active), .dis_en(dis_en)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sw_n = 1'b1; sleep_req = 1'b0; flag_wr = 1'b0; flag_wdata = 1'b0;
    tick(2);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic wr_flag(input logic v);
    flag_wr = 1'b1; flag_wdata = v;
    tick(1);
    flag_wr = 1'b0; flag_wdata = 1'b0;
  endtask

  initial begin
    tick(1);
    do_reset();
    // R1 reset state
    chk("R1 active", is_active, 1'b0);
    chk("R1 dis_en", dis_en, 1'b0);
    chk("R1 flag", flag_rdata, 1'b1);

    // R2/R3/R5 sweep over pulse widths
    for (int w = 1; w <= 6; w++) begin
      do_reset();
      sw_n = 1'b0; tick(w); sw_n = 1'b1; tick(12);
      chk($sformatf("R2 R3 width%0d active", w), is_active, (w >= 3));
      chk($sformatf("R3 width%0d dis_en", w), dis_en, (w >= 3));
      chk($sformatf("R5 width%0d flag", w), flag_rdata, !(w >= 3));
    end

    // R3 latency: outputs change on the 7th edge after the fall
    do_reset();
    sw_n = 1'b0; tick(6);
    chk("R3 not yet at edge 6", is_active, 1'b0);
    tick(1);
    chk("R3 active at edge 7", is_active, 1'b1);
    chk("R3 dis_en at edge 7", dis_en, 1'b1);
    sw_n = 1'b1; tick(10);

    // R6 rearm with the switch released
    wr_flag(1'b1);
    chk("R6 rearm", flag_rdata, 1'b1);

    // R7 write 0 has no effect
    wr_flag(1'b0);
    chk("R7 write0 keeps 1", flag_rdata, 1'b1);

    // R4 low in active mode: mode unchanged, flag cleared (R5, R6 relatch)
    sw_n = 1'b0; tick(10);
    chk("R4 still active", is_active, 1'b1);
    chk("R4 dis_en held", dis_en, 1'b1);
    chk("R6 R5 relatched", flag_rdata, 1'b0);

    // R10 write 1 while low is held
    wr_flag(1'b1);
    chk("R10 new event wins", flag_rdata, 1'b0);
    wr_flag(1'b0);
    chk("R7 write0 keeps 0", flag_rdata, 1'b0);

    // R9 sleep request while held low
    sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
    chk("R9 sleep one cycle", is_active, 1'b0);
    chk("R9 dis_en off", dis_en, 1'b0);
    tick(1);
    chk("R9 rewake", is_active, 1'b1);
    chk("R9 dis_en on", dis_en, 1'b1);

    // R8 plain sleep with the switch released
    sw_n = 1'b1; tick(10);
    sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
    chk("R8 sleep", is_active, 1'b0);
    chk("R8 dis_en off", dis_en, 1'b0);
    tick(5);
    chk("R8 stays asleep", is_active, 1'b0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=hang exp=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule